// File: doc/BRIEF.md
# Float to Extended-Precision Widening Converter

This block takes a 32-bit single-precision or 64-bit double-precision IEEE-754 operand and re-expresses it, with no loss, in the 80-bit extended format: sign, 15-bit exponent with bias 16383, an explicit integer bit, and a 63-bit fraction. An operand that is already 80 bits wide leaves the block unchanged. The widening is exact, so the block does no rounding.

While converting, the block classifies the narrow source. It raises an invalid flag for a signaling NaN and a denormal flag for a subnormal input. It also raises a denormal exception output when the denormal flag is set and the caller has not masked it. A subnormal source is still normalized and delivered when its exception fires. Operands enter through a valid/ready handshake together with a 2-bit format select and the mask bit. The result leaves through a registered valid/ready output one cycle after acceptance.

Top module: `xwiden_conv`

## Requirements
- R1: With format 00 (single), a normal input gives exponent e + 16256, integer bit (bit 63) 1, and the 23-bit fraction placed at result bits 62:40, with zeros below.
- R2: With format 01 (double), a normal input gives exponent e + 15360, integer bit 1, and the 52-bit fraction placed at result bits 62:11, with zeros below.
- R3: A zero input gives a zero of the same sign (exponent 0, integer bit 0, fraction 0). An infinity gives exponent 7FFF, integer bit 1, fraction 0, with the sign kept. Neither raises a flag.
- R4: A narrow subnormal input (exponent field 0, fraction nonzero) is normalized into a result with integer bit 1 and the exactly equal value, and it raises out_dnrm.
- R5: A narrow NaN whose top fraction bit is 0 is signaling. It raises out_inv, and its result has exponent 7FFF, bits 63 and 62 set, and the rest of the payload left-aligned. A narrow NaN whose top fraction bit is 1 converts the same way and raises no flag.
- R6: Formats 10 and 11 pass all 80 bits of in_data through unchanged and never raise out_inv or out_dnrm, even for extended NaN or denormal encodings.
- R7: out_dn_exc equals out_dnrm AND NOT the dnrm_mask captured with the operand. The converted value is delivered whether or not it is set.
- R8: For format 00 only in_data[31:0] is used, and for format 01 only in_data[63:0]. Higher bits have no effect on the result.
- R9: An operand is accepted on a clock edge where in_valid and in_ready are both high, and its result appears with out_valid high after that edge. in_ready is high when out_valid is low or out_ready is high.
- R10: While out_valid is high and out_ready is low, out_valid, out_data and the flags hold their values.
- R11: Synchronous reset clears out_valid and all flags in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can accept an operand |
| in_fmt | input | 2 | Source format: 00 single, 01 double, 10/11 extended |
| in_data | input | 80 | Operand, right-aligned |
| dnrm_mask | input | 1 | 1 suppresses the denormal exception output |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 80 | Extended-format result |
| out_inv | output | 1 | Signaling NaN source flag |
| out_dnrm | output | 1 | Subnormal source flag |
| out_dn_exc | output | 1 | Unmasked denormal exception |

## Verification
The datapath holds no state beyond the output register, so a wrong leading-zero count or a wrong bias shows up in the very result that leaves one cycle after the handshake. It appears as an exponent off by a small integer, or as a mantissa whose integer bit is clear. Vectors at both ends of the subnormal range, along with signaling and quiet NaNs of each width, catch such faults on the first affected operand. A fault in the output register appears as a result that changes, or a valid that drops, while the consumer stalls. Each stall in the bench lasts several cycles so that this is caught.

// File: rtl/xwiden_pkg.sv
package xwiden_pkg;

    localparam int XE_W  = 15;
    localparam int XM_W  = 64;
    localparam int X_W   = XE_W + XM_W + 1;
    localparam int XBIAS = (1 << (XE_W - 1)) - 1;

    typedef enum logic [1:0] {
        FMT_SGL  = 2'b00,
        FMT_DBL  = 2'b01,
        FMT_EXT  = 2'b10,
        FMT_EXT2 = 2'b11
    } src_fmt_e;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_SUB,
        CL_NORM,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } src_cls_e;

    typedef struct packed {
        logic [X_W-1:0] value;
        logic           inv;
        logic           dnrm;
    } xw_conv_t;

    typedef struct packed {
        logic [X_W-1:0] value;
        logic           inv;
        logic           dnrm;
        logic           dn_exc;
    } xw_out_t;

    function automatic logic [X_W-1:0] ext_pack(input logic s,
                                                 input logic [XE_W-1:0] e,
                                                 input logic [XM_W-1:0] m);
        return {s, e, m};
    endfunction

    function automatic logic [XM_W-1:0] mant_special(input logic quiet_set,
                                                     input logic [XM_W-2:0] fal);
        // integer bit forced, optional quiet bit, payload below
        if (quiet_set)
            return {2'b11, fal[XM_W-3:0]};
        return {1'b1, fal};
    endfunction

endpackage

// File: rtl/xw_lzc.sv
module xw_lzc #(
    parameter int W = 23,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i])
                cnt = CW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/xw_src_decode.sv
module xw_src_decode
    import xwiden_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] raw,
    output xw_conv_t       res
);

    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int ADJ  = XBIAS - BIAS;
    localparam int PADW = XM_W - 1 - FW;
    localparam int LZW  = $clog2(FW + 1);

    logic            sgn;
    logic [EW-1:0]   e_fld;
    logic [FW-1:0]   f_fld;
    logic [XM_W-2:0] f_al;
    logic [LZW-1:0]  lz;
    src_cls_e        cls;
    logic [XE_W-1:0] x_exp;
    logic [XM_W-1:0] x_mant;

    assign sgn   = raw[EW+FW];
    assign e_fld = raw[EW+FW-1:FW];
    assign f_fld = raw[FW-1:0];
    assign f_al  = {f_fld, {PADW{1'b0}}};

    xw_lzc #(.W(FW)) u_lzc (
        .vec (f_fld),
        .cnt (lz)
    );

    always_comb begin
        if (e_fld == '0)
            cls = (f_fld == '0) ? CL_ZERO : CL_SUB;
        else if (&e_fld) begin
            if (f_fld == '0)
                cls = CL_INF;
            else
                cls = f_fld[FW-1] ? CL_QNAN : CL_SNAN;
        end else
            cls = CL_NORM;
    end

    always_comb begin
        x_exp  = '0;
        x_mant = '0;
        case (cls)
            CL_NORM: begin
                x_exp  = XE_W'(e_fld) + XE_W'(ADJ);
                x_mant = {1'b1, f_al};
            end
            CL_SUB: begin
                x_exp  = XE_W'(ADJ) - XE_W'(lz);
                x_mant = ({1'b0, f_al} << lz) << 1;
            end
            CL_INF: begin
                x_exp  = '1;
                x_mant = {1'b1, {(XM_W-1){1'b0}}};
            end
            CL_QNAN, CL_SNAN: begin
                x_exp  = '1;
                x_mant = mant_special(1'b1, f_al);
            end
            default: begin
                x_exp  = '0;
                x_mant = '0;
            end
        endcase
    end

    assign res.value = ext_pack(sgn, x_exp, x_mant);
    assign res.inv   = (cls == CL_SNAN);
    assign res.dnrm  = (cls == CL_SUB);

endmodule

// File: rtl/xw_out_stage.sv
module xw_out_stage
    import xwiden_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    output logic    in_ready,
    input  xw_out_t d,
    output logic    out_valid,
    input  logic    out_ready,
    output xw_out_t q
);

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q         <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid)
                q <= d;
        end
    end

endmodule

// File: rtl/xwiden_conv.sv
module xwiden_conv
    import xwiden_pkg::*;
#(
    parameter int SGL_EXP_W  = 8,
    parameter int SGL_FRAC_W = 23,
    parameter int DBL_EXP_W  = 11,
    parameter int DBL_FRAC_W = 52
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [1:0]     in_fmt,
    input  logic [X_W-1:0] in_data,
    input  logic           dnrm_mask,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [X_W-1:0] out_data,
    output logic           out_inv,
    output logic           out_dnrm,
    output logic           out_dn_exc
);

    localparam int N_SRC = 2;

    xw_conv_t narrow_res [N_SRC];
    xw_conv_t sel;
    xw_out_t  stage_d;
    xw_out_t  stage_q;
    src_fmt_e fmt;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam int EW = (g == 0) ? SGL_EXP_W  : DBL_EXP_W;
        localparam int FW = (g == 0) ? SGL_FRAC_W : DBL_FRAC_W;
        xw_src_decode #(.EW(EW), .FW(FW)) u_dec (
            .raw (in_data[EW+FW:0]),
            .res (narrow_res[g])
        );
    end

    assign fmt = src_fmt_e'(in_fmt);

    always_comb begin
        case (fmt)
            FMT_SGL: sel = narrow_res[0];
            FMT_DBL: sel = narrow_res[1];
            default: sel = '{value: in_data, inv: 1'b0, dnrm: 1'b0};
        endcase
    end

    assign stage_d = '{value:  sel.value,
                       inv:    sel.inv,
                       dnrm:   sel.dnrm,
                       dn_exc: sel.dnrm & ~dnrm_mask};

    xw_out_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d         (stage_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (stage_q)
    );

    assign out_data   = stage_q.value;
    assign out_inv    = stage_q.inv;
    assign out_dnrm   = stage_q.dnrm;
    assign out_dn_exc = stage_q.dn_exc;

endmodule

// File: rtl/xwiden_chk.sv
module xwiden_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [1:0]  in_fmt,
    input logic [79:0] in_data,
    input logic        dnrm_mask,
    input logic        out_valid,
    input logic        out_ready,
    input logic [79:0] out_data,
    input logic        out_inv,
    input logic        out_dnrm,
    input logic        out_dn_exc
);

    AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_inv)
                                    && $stable(out_dnrm) && $stable(out_dn_exc)); // R10

    AST_EXT_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (in_fmt inside {2'b10, 2'b11})
        |=> out_data == $past(in_data) && !out_inv && !out_dnrm); // R6

    AST_DN_EXC_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_dn_exc |-> out_dnrm); // R7

    AST_DN_MASKED: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && dnrm_mask |=> !out_dn_exc); // R7

    AST_SNAN_QUIETED: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_inv |-> out_data[78:64] == 15'h7FFF && out_data[63:62] == 2'b11); // R5

    AST_SUB_NORMALIZED: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_dnrm |-> out_data[63] && !out_inv); // R4

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !out_valid && !out_inv && !out_dnrm && !out_dn_exc); // R11

endmodule

bind xwiden_conv xwiden_chk i_chk (.*);

// File: tb/test_xwiden_conv.sv
`timescale 1ns/1ps
module test_xwiden_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_fmt = 2'b00;
    logic [79:0] in_data = '0;
    logic        dnrm_mask = 1'b1;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [79:0] out_data;
    logic        out_inv;
    logic        out_dnrm;
    logic        out_dn_exc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    xwiden_conv i_xwiden_conv (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_fmt(in_fmt),
        .in_data(in_data), .dnrm_mask(dnrm_mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_inv(out_inv), .out_dnrm(out_dnrm), .out_dn_exc(out_dn_exc)
    );

    // {fmt, mask, in, expected, inv, dnrm, req}
    localparam int NV = 24;
    localparam logic [168:0] VECS [NV] = '{
        {2'b00,1'b1,48'h0,32'h3F80_0000, 16'h3FFF,64'h8000_0000_0000_0000, 1'b0,1'b0,4'd1}, // R1
        {2'b00,1'b1,48'h0,32'hC000_0000, 16'hC000,64'h8000_0000_0000_0000, 1'b0,1'b0,4'd1}, // R1
        {2'b00,1'b1,48'h0,32'h3FC0_0000, 16'h3FFF,64'hC000_0000_0000_0000, 1'b0,1'b0,4'd1}, // R1
        {2'b00,1'b0,48'h0,32'h7F7F_FFFF, 16'h407E,64'hFFFF_FF00_0000_0000, 1'b0,1'b0,4'd1}, // R1
        {2'b00,1'b1,48'hDEAD_BEEF_0123,32'h3F80_0000, 16'h3FFF,64'h8000_0000_0000_0000, 1'b0,1'b0,4'd8}, // R8
        {2'b00,1'b1,48'h0,32'h0000_0000, 16'h0000,64'h0, 1'b0,1'b0,4'd3}, // R3
        {2'b00,1'b1,48'h0,32'h8000_0000, 16'h8000,64'h0, 1'b0,1'b0,4'd3}, // R3
        {2'b00,1'b1,48'h0,32'h7F80_0000, 16'h7FFF,64'h8000_0000_0000_0000, 1'b0,1'b0,4'd3}, // R3
        {2'b00,1'b1,48'h0,32'h0000_0001, 16'h3F6A,64'h8000_0000_0000_0000, 1'b0,1'b1,4'd4}, // R4
        {2'b00,1'b0,48'h0,32'h0000_0003, 16'h3F6B,64'hC000_0000_0000_0000, 1'b0,1'b1,4'd4}, // R4
        {2'b00,1'b0,48'h0,32'h8040_0000, 16'hBF80,64'h8000_0000_0000_0000, 1'b0,1'b1,4'd7}, // R7
        {2'b00,1'b1,48'h0,32'h7FC0_0000, 16'h7FFF,64'hC000_0000_0000_0000, 1'b0,1'b0,4'd5}, // R5
        {2'b00,1'b1,48'h0,32'h7F80_0001, 16'h7FFF,64'hC000_0100_0000_0000, 1'b1,1'b0,4'd5}, // R5
        {2'b01,1'b1,16'h0,64'h3FF0_0000_0000_0000, 16'h3FFF,64'h8000_0000_0000_0000, 1'b0,1'b0,4'd2}, // R2
        {2'b01,1'b1,16'hFFFF,64'hBFF8_0000_0000_0000, 16'hBFFF,64'hC000_0000_0000_0000, 1'b0,1'b0,4'd8}, // R8
        {2'b01,1'b1,16'h0,64'h7FEF_FFFF_FFFF_FFFF, 16'h43FE,64'hFFFF_FFFF_FFFF_F800, 1'b0,1'b0,4'd2}, // R2
        {2'b01,1'b1,16'h0,64'h0000_0000_0000_0001, 16'h3BCD,64'h8000_0000_0000_0000, 1'b0,1'b1,4'd4}, // R4
        {2'b01,1'b0,16'h0,64'h000F_FFFF_FFFF_FFFF, 16'h3C00,64'hFFFF_FFFF_FFFF_F000, 1'b0,1'b1,4'd7}, // R7
        {2'b01,1'b1,16'h0,64'h7FF0_0000_0000_0001, 16'h7FFF,64'hC000_0000_0000_0800, 1'b1,1'b0,4'd5}, // R5
        {2'b01,1'b1,16'h0,64'hFFF0_0000_0000_0000, 16'hFFFF,64'h8000_0000_0000_0000, 1'b0,1'b0,4'd3}, // R3
        {2'b01,1'b0,16'h0,64'hFFF8_0000_0000_0000, 16'hFFFF,64'hC000_0000_0000_0000, 1'b0,1'b0,4'd5}, // R5
        {2'b10,1'b0,16'h7FFF,64'hA000_0000_0000_0000, 16'h7FFF,64'hA000_0000_0000_0000, 1'b0,1'b0,4'd6}, // R6
        {2'b11,1'b0,16'h0000,64'h0000_0000_0000_0001, 16'h0000,64'h0000_0000_0000_0001, 1'b0,1'b0,4'd6}, // R6
        {2'b10,1'b0,16'h3FFF,64'h8000_0000_0000_0000, 16'h3FFF,64'h8000_0000_0000_0000, 1'b0,1'b0,4'd6}  // R6
    };

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11 out_valid", 80'(out_valid), 80'd0);
        check("R11 flags", 80'({out_inv, out_dnrm, out_dn_exc}), 80'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 in_ready idle", 80'(in_ready), 80'd1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [168:0] v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            in_fmt    = v[168:167];
            dnrm_mask = v[166];
            in_data   = v[165:86];
            in_valid  = 1'b1;
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check({tag, " valid"}, 80'(out_valid), 80'd1);
            check({tag, " data"}, out_data, v[85:6]);
            check({tag, " flags"}, 80'({out_inv, out_dnrm, out_dn_exc}),
                  80'({v[5], v[4], v[4] & ~v[166]}));
        end

        // R10 / R9: stall with a second operand waiting
        @(negedge clk);
        out_ready = 1'b0;
        in_fmt = 2'b00; dnrm_mask = 1'b1; in_data = {48'h0, 32'h3F80_0000};
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 accepted under stall", 80'(out_valid), 80'd1);
        check("R9 in_ready low when full", 80'(in_ready), 80'd0);
        in_fmt = 2'b01; in_data = {16'h0, 64'hBFF8_0000_0000_0000};
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 held data", out_data, {16'h3FFF, 64'h8000_0000_0000_0000});
            check("R10 held valid", 80'(out_valid), 80'd1);
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 next after drain", out_data, {16'hBFFF, 64'hC000_0000_0000_0000});
        @(posedge clk);
        @(negedge clk);
        check("R9 valid drops", 80'(out_valid), 80'd0);

        // R11: reset while holding a flagged result
        out_ready = 1'b0;
        in_fmt = 2'b00; dnrm_mask = 1'b0; in_data = {48'h0, 32'h0000_0001};
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 exc before reset", 80'(out_dn_exc), 80'd1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R11 valid after reset", 80'(out_valid), 80'd0);
        check("R11 flags after reset", 80'({out_inv, out_dnrm, out_dn_exc}), 80'd0);
        out_ready = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule